// File: doc/BRIEF.md
# Software Reset Strap Latch Sequencer

This block produces the internal software reset of a PHY-style device and captures its hardware configuration straps. A management register write whose upper byte carries the reset bit starts a self-timed reset pulse. The reset bit reads back as set for as long as the pulse lasts and clears itself afterwards. The strap bus carries the mode and address settings. It is sampled once, on the clock edge where the reset is released synchronously. The captured value is then held until the next software reset ends.

The address pins are bidirectional and are normally driven by the device. A second timer starts with the reset and runs longer than it. While this timer runs, the block holds the address-pin output enable low, so the pins act as inputs. Their external pull resistors can then settle well before the capture edge. Both durations are parameters counted in clock cycles. A reset write that arrives while a sequence is running starts both timers again from the new write.

Top module: `swrst_strap_seq`

## Requirements
- R1: A write with `wr_en`=1, `wr_hi`=1 and bit RST_BIT (default 7) of `wr_data` set makes `sw_reset` go to 1 after the clock edge that samples the write.
- R2: A write with `wr_hi`=0, or with bit RST_BIT of `wr_data` clear, has no effect: `sw_reset` stays 0, `addr_oe` stays 1 and `cfg_latched` keeps its value.
- R3: After an accepted write, `sw_reset` stays 1 for exactly RST_CYC clock cycles and then returns to 0.
- R4: `addr_oe` falls on the same edge that `sw_reset` rises and stays 0 for exactly OE_CYC cycles (OE_CYC > RST_CYC). It is 1 at all other times, so it is never 1 while `sw_reset` is 1.
- R5: `cfg_latched` loads the value that `strap_in` has at the clock edge where `sw_reset` falls. Changes on `strap_in` at any other time are ignored.
- R6: An accepted write that arrives while either timer is running restarts both timers from that write. Any strap capture that was pending is dropped, and the capture happens only when the restarted reset ends.
- R7: `rst_bit_rd` reads 1 for every cycle that the reset is active and 0 otherwise.
- R8: While `rst_n` is low at a clock edge, the block clears synchronously: `sw_reset`=0, `addr_oe`=1 and `cfg_latched`=CFG_RST (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Management register write strobe, one cycle |
| wr_hi | input | 1 | Write targets the upper byte of the control register |
| wr_data | input | 8 | Upper-byte write data |
| strap_in | input | STRAP_W | Configuration strap pins (mode and address) |
| sw_reset | output | 1 | Internal software reset, active high |
| rst_bit_rd | output | 1 | Read-back value of the reset bit |
| addr_oe | output | 1 | Output enable for the address pin drivers (0 = pins act as inputs) |
| cfg_latched | output | STRAP_W | Captured strap configuration |

## Verification
The bench builds the block with RST_CYC=5, OE_CYC=12 and an 8-bit strap bus. With these values, every cycle of both windows can be checked one by one within a short run. The short windows also make two timing cases practical to reach. One is a restart inside the reset pulse. The other is a restart in the tail, where only the output-disable window is still running. The bench changes the strap bus on the cycle after each capture edge, which shows that only the release edge loads the captured value.

// File: rtl/swrst_pkg.sv
// Package: shared helpers for the software reset strap sequencer.
// Assumes: lengths passed in are positive cycle counts.
package swrst_pkg;

    // Width of a down counter that must hold the value len.
    function automatic int cnt_width(input int len);
        return (len < 2) ? 1 : $clog2(len + 1);
    endfunction

endpackage

// File: rtl/swrst_wr_decode.sv
// Module: swrst_wr_decode
// Turns a management write strobe into a one-cycle reset request when the
// upper byte is written with the reset bit set.
// Assumes: wr_en is a single-cycle strobe aligned to clk.
module swrst_wr_decode #(
    parameter int RST_BIT = 7
) (
    input  logic       wr_en,
    input  logic       wr_hi,
    input  logic [7:0] wr_data,
    output logic       req
);
    // Only the reset bit of the upper byte matters here.
    logic unused_bits;
    assign unused_bits = ^wr_data;

    // Request: upper-byte write with the reset bit set.
    always_comb begin
        req = wr_en & wr_hi & wr_data[RST_BIT];
    end
endmodule

// File: rtl/swrst_cycle_timer.sv
// Module: swrst_cycle_timer
// Reloadable down counter. A start loads LEN. The counter is active while it
// is nonzero. "expire" marks the edge on which it reaches zero with no new
// start pending.
// Assumes: LEN >= 1; start has priority over counting down.
module swrst_cycle_timer
    import swrst_pkg::*;
#(
    parameter int LEN = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic expire
);
    localparam int CW = cnt_width(LEN);
    localparam logic [CW-1:0] LOADV = CW'(LEN);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] cnt;

    // Counter: reload on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOADV;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    // Status decode from the counter state.
    always_comb begin
        active = (cnt != '0);
        expire = (cnt == ONE) && !start;
    end
endmodule

// File: rtl/swrst_strap_latch.sv
// Module: swrst_strap_latch
// Holding register for the configuration straps, loaded only when told to.
// Assumes: strap_in is stable at the load edge (settled by the external pulls).
module swrst_strap_latch #(
    parameter int               STRAP_W = 10,
    parameter logic [STRAP_W-1:0] CFG_RST = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [STRAP_W-1:0] cfg_q
);
    // Capture register: loads on the release edge, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (load) begin
            cfg_q <= strap_in;
        end
    end
endmodule

// File: rtl/swrst_strap_seq.sv
// Module: swrst_strap_seq (top)
// Software reset sequencer. A reset write starts a self-timed reset of
// RST_CYC cycles and, at the same time, an output-disable window of OE_CYC
// cycles for the address pin drivers. The straps are captured on the edge
// where the reset releases.
// Assumes: OE_CYC > RST_CYC >= 1; synchronous active-low rst_n.
module swrst_strap_seq #(
    parameter int                 RST_CYC = 13,
    parameter int                 OE_CYC  = 43,
    parameter int                 STRAP_W = 10,
    parameter int                 RST_BIT = 7,
    parameter logic [STRAP_W-1:0] CFG_RST = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [7:0]         wr_data,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               sw_reset,
    output logic               rst_bit_rd,
    output logic               addr_oe,
    output logic [STRAP_W-1:0] cfg_latched
);
    logic req;
    logic rst_act, rst_exp;
    logic oe_act;
    logic oe_exp_unused;

    // Write decode: reset request strobe.
    swrst_wr_decode #(.RST_BIT(RST_BIT)) u_dec (
        .wr_en  (wr_en),
        .wr_hi  (wr_hi),
        .wr_data(wr_data),
        .req    (req)
    );

    // Reset pulse timer.
    swrst_cycle_timer #(.LEN(RST_CYC)) u_rst_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (req),
        .active(rst_act),
        .expire(rst_exp)
    );

    // Address driver disable timer.
    swrst_cycle_timer #(.LEN(OE_CYC)) u_oe_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (req),
        .active(oe_act),
        .expire(oe_exp_unused)
    );

    // Strap capture on the reset release edge.
    swrst_strap_latch #(.STRAP_W(STRAP_W), .CFG_RST(CFG_RST)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rst_exp),
        .strap_in(strap_in),
        .cfg_q   (cfg_latched)
    );

    // Output mapping.
    always_comb begin
        sw_reset   = rst_act;
        rst_bit_rd = rst_act;
        addr_oe    = !oe_act;
    end
endmodule

// File: rtl/swrst_strap_seq_chk.sv
// Module: swrst_strap_seq_chk
// Port-level checker for swrst_strap_seq. It keeps a count of the cycles
// since the last accepted write, which is used to measure both windows.
// Assumes: OE_CYC > RST_CYC.
module swrst_strap_seq_chk #(
    parameter int RST_CYC = 13,
    parameter int OE_CYC  = 43,
    parameter int STRAP_W = 10,
    parameter int RST_BIT = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               wr_hi,
    input logic [7:0]         wr_data,
    input logic [STRAP_W-1:0] strap_in,
    input logic               sw_reset,
    input logic               rst_bit_rd,
    input logic               addr_oe,
    input logic [STRAP_W-1:0] cfg_latched
);
    localparam int SW = $clog2(OE_CYC + 2);
    localparam logic [SW-1:0] SMAX = SW'(OE_CYC + 1);

    logic          trig;
    logic [SW-1:0] since;

    assign trig = wr_en && wr_hi && wr_data[RST_BIT];

    // Cycles since the last accepted write, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          since <= SMAX;
        else if (trig)       since <= '0;
        else if (since != SMAX) since <= since + SW'(1);
    end

    a_r1_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> sw_reset);

    a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_reset) && $past(rst_n)) |-> (since == SW'(RST_CYC)));

    a_r4_oe_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_oe) && $past(rst_n)) |-> (since == SW'(OE_CYC)));

    a_r4_oe_off_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |-> !addr_oe);

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_reset) && $past(rst_n)) |-> (cfg_latched == $past(strap_in)));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg_latched) && $past(rst_n)) |-> $fell(sw_reset));

    a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
        rst_bit_rd == sw_reset);

    a_r8_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!sw_reset && addr_oe));
endmodule

bind swrst_strap_seq swrst_strap_seq_chk #(
    .RST_CYC(RST_CYC),
    .OE_CYC (OE_CYC),
    .STRAP_W(STRAP_W),
    .RST_BIT(RST_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_hi      (wr_hi),
    .wr_data    (wr_data),
    .strap_in   (strap_in),
    .sw_reset   (sw_reset),
    .rst_bit_rd (rst_bit_rd),
    .addr_oe    (addr_oe),
    .cfg_latched(cfg_latched)
);

// File: tb/swrst_strap_seq_tb.sv
// Bench for swrst_strap_seq: a vector table of writes, then directed cases.
module swrst_strap_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RC = 5;
    localparam int OC = 12;
    localparam int SWD = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           wr_hi = 1'b0;
    logic [7:0]     wr_data = '0;
    logic [SWD-1:0] strap_in = '0;
    logic           sw_reset, rst_bit_rd, addr_oe;
    logic [SWD-1:0] cfg_latched;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swrst_strap_seq #(.RST_CYC(RC), .OE_CYC(OC), .STRAP_W(SWD), .RST_BIT(7)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .strap_in(strap_in), .sw_reset(sw_reset), .rst_bit_rd(rst_bit_rd),
        .addr_oe(addr_oe), .cfg_latched(cfg_latched)
    );

    // Vector: {wr_hi, wr_data, expect_trigger, strap}
    localparam logic [17:0] VEC [7] = '{
        {1'b1, 8'h80, 1'b1, 8'hA5},
        {1'b0, 8'h80, 1'b0, 8'h11},
        {1'b1, 8'h7F, 1'b0, 8'h22},
        {1'b1, 8'hFF, 1'b1, 8'h3C},
        {1'b1, 8'h00, 1'b0, 8'h44},
        {1'b1, 8'h80, 1'b1, 8'h00},
        {1'b1, 8'hC0, 1'b1, 8'hFF}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one write strobe; call at a falling edge.
    task automatic issue(input logic hi, input logic [7:0] d);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
    endtask

    // Follow a full sequence after issue(); checks every cycle of both windows.
    task automatic run_seq(input logic [SWD-1:0] s, input logic [SWD-1:0] old);
        for (int k = 1; k <= OC + 1; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            chk(sw_reset == (k <= RC), "R3 sw_reset window", sw_reset, (k <= RC));
            chk(rst_bit_rd == (k <= RC), "R7 readback", rst_bit_rd, (k <= RC));
            chk(addr_oe == (k > OC), "R4 addr_oe window", addr_oe, (k > OC));
            if (k <= RC) chk(cfg_latched == old, "R5 hold before release", cfg_latched, old);
            else         chk(cfg_latched == s, "R5 capture at release", cfg_latched, s);
            if (k == RC + 1) strap_in = ~s;
        end
    endtask

    initial begin
        logic [SWD-1:0] cur;
        repeat (3) @(negedge clk);
        chk(sw_reset == 1'b0, "R8 reset sw_reset", sw_reset, 0);
        chk(addr_oe == 1'b1, "R8 reset addr_oe", addr_oe, 1);
        chk(cfg_latched == '0, "R8 reset cfg", cfg_latched, 0);
        chk(rst_bit_rd == 1'b0, "R8 reset readback", rst_bit_rd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cur = '0;

        // Table walk: R1 accepted writes, R2 ignored writes.
        for (int i = 0; i < 7; i++) begin
            strap_in = VEC[i][7:0];
            issue(VEC[i][17], VEC[i][16:9]);
            if (VEC[i][8]) begin
                @(negedge clk);
                wr_en = 1'b0;
                chk(sw_reset == 1'b1, "R1 reset starts", sw_reset, 1);
                chk(addr_oe == 1'b0, "R4 oe off at start", addr_oe, 0);
                // Continue the same sequence from cycle 2.
                for (int k = 2; k <= OC + 1; k++) begin
                    @(negedge clk);
                    chk(sw_reset == (k <= RC), "R3 sw_reset window", sw_reset, (k <= RC));
                    chk(rst_bit_rd == (k <= RC), "R7 readback", rst_bit_rd, (k <= RC));
                    chk(addr_oe == (k > OC), "R4 addr_oe window", addr_oe, (k > OC));
                    if (k <= RC) chk(cfg_latched == cur, "R5 hold before release", cfg_latched, cur);
                    else         chk(cfg_latched == VEC[i][7:0], "R5 capture at release", cfg_latched, VEC[i][7:0]);
                    if (k == RC + 1) strap_in = ~VEC[i][7:0];
                end
                cur = VEC[i][7:0];
            end else begin
                for (int k = 1; k <= 4; k++) begin
                    @(negedge clk);
                    wr_en = 1'b0;
                    chk(sw_reset == 1'b0, "R2 no reset", sw_reset, 0);
                    chk(addr_oe == 1'b1, "R2 oe untouched", addr_oe, 1);
                    chk(cfg_latched == cur, "R2 cfg untouched", cfg_latched, cur);
                end
            end
        end

        // R6: restart inside the reset pulse.
        strap_in = 8'h5A;
        issue(1'b1, 8'h80);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            chk(sw_reset == 1'b1, "R6 first pulse active", sw_reset, 1);
        end
        strap_in = 8'h6B;
        issue(1'b1, 8'h80);
        run_seq(8'h6B, cur);
        cur = 8'h6B;

        // R6: restart in the tail where only the disable window runs.
        strap_in = 8'h19;
        issue(1'b1, 8'h80);
        for (int k = 1; k <= RC + 2; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
        chk(sw_reset == 1'b0, "R6 tail reset done", sw_reset, 0);
        chk(addr_oe == 1'b0, "R6 tail oe still off", addr_oe, 0);
        chk(cfg_latched == 8'h19, "R6 tail first capture", cfg_latched, 8'h19);
        strap_in = 8'h2E;
        issue(1'b1, 8'h80);
        run_seq(8'h2E, 8'h19);
        cur = 8'h2E;

        // R8: synchronous reset in the middle of a sequence.
        strap_in = 8'h77;
        issue(1'b1, 8'h80);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sw_reset == 1'b0, "R8 mid reset sw_reset", sw_reset, 0);
        chk(addr_oe == 1'b1, "R8 mid reset addr_oe", addr_oe, 1);
        chk(cfg_latched == '0, "R8 mid reset cfg", cfg_latched, 0);
        rst_n = 1'b1;
        repeat (OC + 2) @(negedge clk);
        chk(cfg_latched == '0, "R8 no capture after abort", cfg_latched, 0);
        chk(addr_oe == 1'b1, "R8 oe stays on after abort", addr_oe, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule